// File: doc/BRIEF.md
# SRAM Sleep-Mode Power Controller

This block sits between a host and a synchronous SRAM core and governs a low-power sleep state. An active-high sleep request pin, asynchronous to the clock, is first synchronized. Once the synchronized request is seen, the block waits a fixed entry delay and then puts the core to sleep. While asleep, host commands are accepted and discarded, the core sees only deselect, and the read-data path is turned off so that the pad drivers can float. The core is never written while it sleeps, so its contents are kept.

When the request falls, the block runs a recovery window of a set number of cycles. During that window, deselect and read commands reach the core. Any other command is consumed, dropped, and reported with a one-cycle error pulse. Asking for sleep while the core still reports work in flight raises a violation pulse, because that work may not complete.

Host commands use a valid/ready handshake. In the awake and entering states, `cmd_ready` follows `core_ready`, so the core can apply back-pressure. Where a command is dropped (asleep, or a blocked command during recovery), `cmd_ready` is held high so that the host never stalls. Read return has no back-pressure: `rd_valid` marks data the host must take.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset, and while the synchronized request is low, `pwr_state` reads 00 (awake), `rd_oe` is 1, and `wr_err` and `viol_err` are 0.
- R2: `sleep_req` passes through a two-stage synchronizer. Taking the request as set before rising edge 1, `pwr_state` still reads 00 after edge 2.
- R3: Entry takes two cycles after the synchronized request is seen. For a request set before edge 1, `pwr_state` reads 01 (entering) after edge 3 and 10 (asleep) after edge 4.
- R4: While `pwr_state` is 10, `core_valid` is 0. `cmd_ready` is 1 whatever `core_ready` is, and every accepted command is discarded.
- R5: While `pwr_state` is 10, `rd_oe`, `rd_valid` and `rd_data` are all 0. When not asleep, `rd_data`/`rd_valid` follow `core_rdata`/`core_rvalid` and `rd_oe` is 1.
- R6: The block stays asleep for as long as the synchronized request stays high.
- R7: For a release set before edge 1, `pwr_state` reads 10 after edge 2, reads 11 (recovering) for RECOV_CYC cycles from edge 3, and then reads 00.
- R8: During recovery, op 00 (deselect) and op 01 (read) pass to the core. Op 10 (write) and op 11 (burst) are accepted with `cmd_ready`=1 and dropped.
- R9: `wr_err` is high for exactly the cycle that follows each dropped recovery command.
- R10: `viol_err` pulses for one cycle, together with the awake-to-entering step, when `core_busy` is high at that step.
- R11: In the awake and entering states, `cmd_ready` equals `core_ready`, `core_valid` equals `cmd_valid`, and op, address and write data are forwarded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Host command ready |
| cmd_op | input | 2 | Op: 00 deselect, 01 read, 10 write, 11 burst |
| cmd_addr | input | ADDR_W | Host address |
| cmd_wdata | input | DATA_W | Host write data |
| core_valid | output | 1 | Command valid to the core |
| core_ready | input | 1 | Core ready |
| core_op | output | 2 | Op to the core |
| core_addr | output | ADDR_W | Address to the core |
| core_wdata | output | DATA_W | Write data to the core |
| core_busy | input | 1 | Core has operations in flight |
| core_rdata | input | DATA_W | Read data from the core |
| core_rvalid | input | 1 | Read data valid from the core |
| rd_valid | output | 1 | Read data valid to the host |
| rd_data | output | DATA_W | Read data to the host |
| rd_oe | output | 1 | Output-enable for the data pad drivers |
| pwr_state | output | 2 | 00 awake, 01 entering, 10 asleep, 11 recovering |
| wr_err | output | 1 | A command was dropped during recovery |
| viol_err | output | 1 | Sleep was requested while the core was busy |

## Verification
The following are checked by properties on every cycle:
- the core sees no command while asleep;
- the output enable and read data are low while asleep;
- no write or burst reaches the core during recovery;
- the block reaches asleep only through entering, and leaves asleep only into recovery;
- the error pulses have the right cause;
- the handshake passes straight through while awake.

Only the bench scenarios can show the exact cycle counts. These are the synchronizer latency, the two-cycle entry delay and the recovery length. The bench scenarios also show which commands reach the core, in order, compared against a scoreboard.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;
  typedef enum logic [1:0] {
    OP_DESEL = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_BURST = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'b00,
    ST_ENTER = 2'b01,
    ST_SLEEP = 2'b10,
    ST_RECOV = 2'b11
  } pwr_st_e;
endpackage

// File: rtl/sram_sleep_sync.sv
module sram_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sram_sleep_fsm.sv
module sram_sleep_fsm
  import sram_sleep_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_s,
  input  logic    busy,
  output pwr_st_e st,
  output logic    viol
);
  localparam int MAXC = (ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 2);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

  pwr_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
      viol  <= 1'b0;
    end else begin
      viol <= 1'b0;
      unique case (st_q)
        ST_AWAKE: if (req_s) begin
          st_q  <= ST_ENTER;
          cnt_q <= '0;
          viol  <= busy;
        end
        ST_ENTER: begin
          if (!req_s)                  st_q <= ST_AWAKE;
          else if (cnt_q == ENTRY_LAST) st_q <= ST_SLEEP;
          else                         cnt_q <= cnt_q + 1'b1;
        end
        ST_SLEEP: if (!req_s) begin
          st_q  <= ST_RECOV;
          cnt_q <= '0;
        end
        ST_RECOV: begin
          if (req_s) begin
            st_q  <= ST_ENTER;
            cnt_q <= '0;
          end else if (cnt_q == RECOV_LAST) st_q <= ST_AWAKE;
          else                              cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_AWAKE;
      endcase
    end
  end

  assign st = st_q;
endmodule

// File: rtl/sram_sleep_gate.sv
module sram_sleep_gate
  import sram_sleep_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwr_st_e           st,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              core_valid,
  input  logic              core_ready,
  output logic [1:0]        core_op,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  input  logic [DATA_W-1:0] core_rdata,
  input  logic              core_rvalid,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              wr_err
);
  logic pass_all, in_recov, safe_op, forward;

  always_comb begin
    pass_all = (st == ST_AWAKE) || (st == ST_ENTER);
    in_recov = (st == ST_RECOV);
    safe_op  = (cmd_op == OP_DESEL) || (cmd_op == OP_READ);
    forward  = pass_all || (in_recov && safe_op);
  end

  assign core_valid = cmd_valid && forward;
  assign cmd_ready  = forward ? core_ready : 1'b1;
  assign core_op    = cmd_op;
  assign core_addr  = cmd_addr;
  assign core_wdata = cmd_wdata;

  assign rd_oe    = (st != ST_SLEEP);
  assign rd_valid = rd_oe && core_rvalid;
  assign rd_data  = rd_oe ? core_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= in_recov && cmd_valid && !safe_op;
  end
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
  import sram_sleep_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              core_valid,
  input  logic              core_ready,
  output logic [1:0]        core_op,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  input  logic              core_busy,
  input  logic [DATA_W-1:0] core_rdata,
  input  logic              core_rvalid,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic [1:0]        pwr_state,
  output logic              wr_err,
  output logic              viol_err
);
  logic    req_s;
  pwr_st_e st;

  sram_sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sleep_req), .sync_out(req_s)
  );

  sram_sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .busy(core_busy),
    .st(st), .viol(viol_err)
  );

  sram_sleep_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .st(st),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
    .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_oe(rd_oe), .wr_err(wr_err)
  );

  assign pwr_state = st;
endmodule

// File: rtl/sram_sleep_ctrl_chk.sv
module sram_sleep_ctrl_chk
  import sram_sleep_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              core_valid,
  input logic              core_ready,
  input logic [1:0]        core_op,
  input logic              core_busy,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_oe,
  input logic [1:0]        pwr_state,
  input logic              wr_err,
  input logic              viol_err
);
  p_asleep_no_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == ST_SLEEP |-> !core_valid && cmd_ready);

  p_asleep_outputs_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == ST_SLEEP |-> !rd_oe && !rd_valid && rd_data == '0);

  p_sleep_via_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_SLEEP && $past(pwr_state) != ST_SLEEP) |-> $past(pwr_state) == ST_ENTER);

  p_wake_via_recov_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_state) == ST_SLEEP |-> (pwr_state == ST_SLEEP || pwr_state == ST_RECOV));

  p_recov_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_RECOV && core_valid) |-> (core_op == OP_DESEL || core_op == OP_READ));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(pwr_state == ST_RECOV && cmd_valid && cmd_ready &&
                     (cmd_op == OP_WRITE || cmd_op == OP_BURST)));

  p_viol_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_err |-> pwr_state == ST_ENTER && $past(pwr_state) == ST_AWAKE && $past(core_busy));

  p_pass_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_AWAKE || pwr_state == ST_ENTER) |->
      (cmd_ready == core_ready && core_valid == cmd_valid));
endmodule

bind sram_sleep_ctrl sram_sleep_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_sleep_ctrl_tb.sv
module sram_sleep_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [31:0] data;
  } item_t;

  logic        clk = 0, rst_n = 0, sleep_req = 0;
  logic        cmd_valid = 0, core_ready = 1, core_busy = 0, core_rvalid = 0;
  logic [1:0]  cmd_op = 0;
  logic [15:0] cmd_addr = 0;
  logic [31:0] cmd_wdata = 0, core_rdata = 0;
  logic        cmd_ready, core_valid, rd_valid, rd_oe, wr_err, viol_err;
  logic [1:0]  core_op, pwr_state;
  logic [15:0] core_addr;
  logic [31:0] core_wdata, rd_data;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  item_t q[$];

  sram_sleep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_busy(core_busy),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_oe(rd_oe),
    .pwr_state(pwr_state), .wr_err(wr_err), .viol_err(viol_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d, input bit pass);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    if (pass) q.push_back('{op, a, d});
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // monitor: pops expected core commands, samples just before each rising edge
  initial begin
    item_t got, exp;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/2 - 1);
      if (rst_n && core_valid && core_ready) begin
        got = '{core_op, core_addr, core_wdata};
        if (q.size() == 0) chk(0, "R4/R8 unexpected core command", 64'(got), 0);
        else begin
          exp = q.pop_front();
          chk(got == exp, "R11/R8 core command", 64'(got), 64'(exp));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pwr_state == 2'b00, "R1 state", pwr_state, 0);
    chk(rd_oe == 1, "R1 rd_oe", rd_oe, 1);
    chk(!wr_err && !viol_err, "R1 flags", {wr_err, viol_err}, 0);

    // R11 awake traffic through scoreboard
    send(2'b10, 16'h0010, 32'hA5A5_0001, 1);
    send(2'b01, 16'h0010, 32'h0, 1);
    send(2'b00, 16'h0000, 32'h0, 1);
    send(2'b11, 16'h0011, 32'hA5A5_0002, 1);
    // R11 back-pressure follows core_ready
    @(negedge clk);
    core_ready = 0; cmd_valid = 1; cmd_op = 2'b10;
    #1;
    chk(cmd_ready == 0, "R11 back-pressure", cmd_ready, 0);
    chk(core_valid == 1, "R11 valid forwarded", core_valid, 1);
    @(negedge clk);
    cmd_valid = 0; core_ready = 1;
    // R5 read path awake
    core_rvalid = 1; core_rdata = 32'hDEAD_BEEF;
    #1;
    chk(rd_valid && rd_data == 32'hDEAD_BEEF, "R5 read path awake", rd_data, 32'hDEAD_BEEF);

    // sleep entry sequence
    @(negedge clk); sleep_req = 1;
    @(negedge clk); chk(pwr_state == 2'b00, "R2 sync edge1", pwr_state, 0);
    @(negedge clk); chk(pwr_state == 2'b00, "R2 sync edge2", pwr_state, 0);
    @(negedge clk); chk(pwr_state == 2'b01, "R3 entering", pwr_state, 1);
    chk(viol_err == 0, "R10 no violation when idle", viol_err, 0);
    @(negedge clk); chk(pwr_state == 2'b10, "R3 asleep", pwr_state, 2);

    // asleep behaviour
    chk(rd_oe == 0 && rd_valid == 0 && rd_data == 0, "R5 outputs off", {rd_oe, rd_valid, rd_data}, 0);
    core_ready = 0;
    #1;
    cmd_valid = 1; cmd_op = 2'b10;
    #1;
    chk(cmd_ready == 1 && core_valid == 0, "R4 command dropped", {cmd_ready, core_valid}, 2'b10);
    cmd_valid = 0; core_ready = 1;
    send(2'b10, 16'h0010, 32'hBAD0_BAD0, 0);
    send(2'b01, 16'h0020, 32'h0, 0);
    repeat (20) @(negedge clk);
    chk(pwr_state == 2'b10, "R6 held asleep", pwr_state, 2);

    // release and recovery
    sleep_req = 0;
    @(negedge clk); chk(pwr_state == 2'b10, "R7 asleep edge1", pwr_state, 2);
    @(negedge clk); chk(pwr_state == 2'b10, "R7 asleep edge2", pwr_state, 2);
    @(negedge clk); chk(pwr_state == 2'b11, "R7 recovering", pwr_state, 3);
    cmd_valid = 1; cmd_op = 2'b10; cmd_addr = 16'h0030; cmd_wdata = 32'h1234_5678;
    #1;
    chk(cmd_ready == 1 && core_valid == 0, "R8 write dropped", {cmd_ready, core_valid}, 2'b10);
    @(negedge clk);
    chk(wr_err == 1, "R9 error pulse", wr_err, 1);
    chk(pwr_state == 2'b11, "R7 recovering 2", pwr_state, 3);
    cmd_op = 2'b01; cmd_addr = 16'h0031;
    q.push_back('{2'b01, 16'h0031, 32'h1234_5678});
    #1;
    chk(core_valid == 1, "R8 read passes", core_valid, 1);
    @(negedge clk);
    cmd_valid = 0;
    chk(wr_err == 0, "R9 one cycle", wr_err, 0);
    chk(pwr_state == 2'b00, "R7 awake again", pwr_state, 0);
    chk(rd_oe == 1, "R5 rd_oe back", rd_oe, 1);

    // violation on entry while busy
    @(negedge clk); core_busy = 1; sleep_req = 1;
    @(negedge clk); chk(viol_err == 0, "R10 edge1", viol_err, 0);
    @(negedge clk); chk(viol_err == 0, "R10 edge2", viol_err, 0);
    @(negedge clk); chk(viol_err == 1 && pwr_state == 2'b01, "R10 violation", {viol_err, pwr_state}, 3'b101);
    @(negedge clk); chk(viol_err == 0, "R10 pulse ends", viol_err, 0);
    core_busy = 0; sleep_req = 0;
    repeat (8) @(negedge clk);
    chk(pwr_state == 2'b00, "R1 awake after release", pwr_state, 0);
    send(2'b10, 16'h0040, 32'h0BAD_F00D, 1);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11 scoreboard drained", q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule